// File: doc/BRIEF.md
# Ones'-Complement Shift and Rotate Unit

This block performs the shift group of an 18-bit accumulator machine. It moves the accumulator (AC), the in-out register (IO), or both joined as one 36-bit word. Each move is either a cyclic rotate or an arithmetic shift under ones'-complement rules. The operation is decoded from the 13 low bits of the instruction word. Every request takes a single clock, whatever step count it asks for.

The step count is not a binary number. It is the number of set bits in a 9-bit field, so a count of one can be written nine ways, and the largest count is nine. When AC and IO are joined for an arithmetic shift, IO is a magnitude extension below AC, and the AC sign governs the pair.

A controller presents the instruction, the current AC and the current IO, and raises `exec_i` for one cycle. On the next clock edge the block registers the new AC and IO on `ac_o` and `io_o` and pulses `done_o`.

Top module: `sru_core`

## Requirements
- R1: Field layout of `instr_i[12:0]`. Bit 12 gives the direction (0 = left, 1 = right). Bit 11 gives the kind (0 = rotate, 1 = arithmetic shift). Bits 10:9 select the target (01 = AC, 10 = IO, 11 = AC and IO joined, 00 = none). Bits 8:0 form the step field. Bit 17 of each data word is the sign and most significant bit.
- R2: The step count equals the number of ones in `instr_i[8:0]`, from 0 to 9. Any single set bit in that field gives exactly one step.
- R3: A rotate treats the selected register as a ring. In joined mode the ring is `{AC,IO}`, with AC above IO, so a right rotate moves IO bit 0 into AC bit 17.
- R4: An arithmetic right shift keeps bit 17 and fills each vacated high magnitude bit with the sign.
- R5: An arithmetic left shift keeps bit 17 and fills each vacated low bit with the sign. Magnitude bits moved past bit 16 are lost.
- R6: A joined arithmetic shift acts on `{AC,IO}` as one 36-bit ones'-complement word whose only sign is AC bit 17. Bits cross between AC bit 0 and IO bit 17.
- R7: A register that is not selected comes out equal to its input. Target 00 passes both registers through unchanged.
- R8: A step field of zero leaves both registers unchanged, whatever the other fields hold.
- R9: When `exec_i` is high at a clock edge, that edge loads the results onto `ac_o`/`io_o` and sets `done_o` high for that cycle only.
- R10: Reset (`rst_n` low) clears `ac_o`, `io_o` and `done_o`. While `exec_i` is low, `ac_o` and `io_o` hold and `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Execute strobe, one cycle per operation |
| instr_i | input | 13 | Low bits of the shift-group instruction word |
| ac_i | input | 18 | Current accumulator value |
| io_i | input | 18 | Current in-out register value |
| ac_o | output | 18 | Registered new accumulator value |
| io_o | output | 18 | Registered new in-out register value |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `exec_i` is low during reset. They also assume that `instr_i`, `ac_i` and `io_i` are settled at the edge where `exec_i` is sampled, because every property compares registered outputs with the inputs held one edge earlier. The stimulus meets both assumptions: it keeps the strobe low until reset is over, and it changes inputs only at falling edges. It then sweeps every direction, kind, target and step-field value over several data patterns, including all-ones and maximum-magnitude negative words.

// File: rtl/sru_pkg.sv
package sru_pkg;

    // Width of one data register; the joined pair is twice this.
    parameter int unsigned WORD_W  = 18;
    // Width of the population-coded step field.
    parameter int unsigned FIELD_W = 9;

    localparam int unsigned PAIR_W  = 2 * WORD_W;
    localparam int unsigned STEP_W  = $clog2(FIELD_W + 1);
    localparam int unsigned INSTR_W = FIELD_W + 4;

    // Target selection, bits 10:9 of the instruction slice.
    typedef enum logic [1:0] {
        TGT_NONE  = 2'b00,
        TGT_ACC   = 2'b01,
        TGT_INOUT = 2'b10,
        TGT_PAIR  = 2'b11
    } tgt_e;

    typedef struct packed {
        logic              right;
        logic              arith;
        tgt_e              tgt;
        logic [STEP_W-1:0] steps;
    } sru_op_t;

    typedef struct packed {
        logic [WORD_W-1:0] ac;
        logic [WORD_W-1:0] io;
        logic              done;
    } sru_state_t;

endpackage

// File: rtl/sru_popcount.sv
module sru_popcount #(
    parameter int unsigned IN_W  = 9,
    parameter int unsigned OUT_W = 4
) (
    input  logic [IN_W-1:0]  bits_i,
    output logic [OUT_W-1:0] count_o
);

    // Running sums, one stage per input bit.
    logic [OUT_W-1:0] partial [IN_W+1];

    assign partial[0] = '0;

    genvar g;
    generate
        for (g = 0; g < IN_W; g++) begin : g_stage
            assign partial[g+1] = partial[g] + OUT_W'(bits_i[g]);
        end
    endgenerate

    assign count_o = partial[IN_W];

endmodule

// File: rtl/sru_decode.sv
module sru_decode
    import sru_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output sru_op_t            op_o
);

    logic [STEP_W-1:0] steps;

    sru_popcount #(
        .IN_W  (FIELD_W),
        .OUT_W (STEP_W)
    ) u_count (
        .bits_i  (instr_i[FIELD_W-1:0]),
        .count_o (steps)
    );

    always_comb begin
        op_o.right = instr_i[FIELD_W+3];
        op_o.arith = instr_i[FIELD_W+2];
        op_o.tgt   = tgt_e'(instr_i[FIELD_W+1:FIELD_W]);
        op_o.steps = steps;
    end

endmodule

// File: rtl/sru_mover.sv
module sru_mover #(
    parameter int unsigned W      = 18,
    parameter int unsigned STEP_W = 4
) (
    input  logic [W-1:0]      data_i,
    input  logic [STEP_W-1:0] steps_i,
    input  logic              right_i,
    input  logic              arith_i,
    output logic [W-1:0]      data_o
);

    localparam int unsigned MAG_W = W - 1;

    logic [2*W-1:0]   ring;
    logic [2*W-1:0]   ring_l;
    logic [2*W-1:0]   ring_r;
    logic [W-1:0]     rot_res;
    logic             sign;
    logic [MAG_W-1:0] mag;
    logic [MAG_W-1:0] fill;
    logic [MAG_W-1:0] ones;
    logic [MAG_W-1:0] keep_r;
    logic [MAG_W-1:0] keep_l;
    logic [MAG_W-1:0] mag_res;

    // Rotate: both copies of the word side by side; pick the window.
    always_comb begin
        ring    = {data_i, data_i};
        ring_l  = ring << steps_i;
        ring_r  = ring >> steps_i;
        rot_res = right_i ? ring_r[W-1:0] : ring_l[2*W-1:W];
    end

    // Arithmetic: sign stays, vacated magnitude bits copy the sign.
    always_comb begin
        sign    = data_i[W-1];
        mag     = data_i[MAG_W-1:0];
        fill    = {MAG_W{sign}};
        ones    = '1;
        keep_r  = ones >> steps_i;
        keep_l  = ones << steps_i;
        if (right_i) begin
            mag_res = (mag >> steps_i) | (fill & ~keep_r);
        end else begin
            mag_res = (mag << steps_i) | (fill & ~keep_l);
        end
    end

    assign data_o = arith_i ? {sign, mag_res} : rot_res;

endmodule

// File: rtl/sru_core.sv
module sru_core
    import sru_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exec_i,
    input  logic [12:0]        instr_i,
    input  logic [17:0]        ac_i,
    input  logic [17:0]        io_i,
    output logic [17:0]        ac_o,
    output logic [17:0]        io_o,
    output logic               done_o
);

    sru_op_t           op;
    logic [WORD_W-1:0] single_in  [2];
    logic [WORD_W-1:0] single_out [2];
    logic [PAIR_W-1:0] pair_out;
    sru_state_t        state_d;
    sru_state_t        state_q;

    sru_decode u_decode (
        .instr_i (instr_i),
        .op_o    (op)
    );

    assign single_in[0] = ac_i;
    assign single_in[1] = io_i;

    // One mover per register on its own, index 0 = AC, 1 = IO.
    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_single
            sru_mover #(
                .W      (WORD_W),
                .STEP_W (STEP_W)
            ) u_mover (
                .data_i  (single_in[g]),
                .steps_i (op.steps),
                .right_i (op.right),
                .arith_i (op.arith),
                .data_o  (single_out[g])
            );
        end
    endgenerate

    // Joined pair: AC is the upper half and carries the only sign.
    sru_mover #(
        .W      (PAIR_W),
        .STEP_W (STEP_W)
    ) u_pair (
        .data_i  ({ac_i, io_i}),
        .steps_i (op.steps),
        .right_i (op.right),
        .arith_i (op.arith),
        .data_o  (pair_out)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = exec_i;
        if (exec_i) begin
            state_d.ac = ac_i;
            state_d.io = io_i;
            unique case (op.tgt)
                TGT_ACC:   state_d.ac = single_out[0];
                TGT_INOUT: state_d.io = single_out[1];
                TGT_PAIR:  {state_d.ac, state_d.io} = pair_out;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ac_o   = state_q.ac;
    assign io_o   = state_q.io;
    assign done_o = state_q.done;

endmodule

// File: rtl/sru_checker.sv
module sru_checker #(
    parameter int unsigned WORD_W  = 18,
    parameter int unsigned INSTR_W = 13
) (
    input logic               clk,
    input logic               rst_n,
    input logic               exec_i,
    input logic [INSTR_W-1:0] instr_i,
    input logic [WORD_W-1:0]  ac_i,
    input logic [WORD_W-1:0]  io_i,
    input logic [WORD_W-1:0]  ac_o,
    input logic [WORD_W-1:0]  io_o,
    input logic               done_o
);

    localparam int unsigned FIELD_W = INSTR_W - 4;

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (done_o == $past(exec_i)));

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(exec_i)) |-> ($stable(ac_o) && $stable(io_o)));

    assert_zero_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(exec_i) && ($past(instr_i[FIELD_W-1:0]) == '0))
        |-> (ac_o == $past(ac_i) && io_o == $past(io_i)));

    assert_rotate_keeps_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(exec_i) && !$past(instr_i[FIELD_W+2]))
        |-> ($countones({ac_o, io_o}) == $countones($past({ac_i, io_i}))));

    assert_shift_keeps_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(exec_i) && $past(instr_i[FIELD_W+2]) && $past(instr_i[FIELD_W]))
        |-> (ac_o[WORD_W-1] == $past(ac_i[WORD_W-1])));

    assert_unselected_io_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(exec_i) && !$past(instr_i[FIELD_W+1]))
        |-> (io_o == $past(io_i)));

endmodule

bind sru_core sru_checker #(
    .WORD_W  (18),
    .INSTR_W (13)
) u_sru_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .exec_i  (exec_i),
    .instr_i (instr_i),
    .ac_i    (ac_i),
    .io_i    (io_i),
    .ac_o    (ac_o),
    .io_o    (io_o),
    .done_o  (done_o)
);

// File: tb/sru_core_bench.sv
module sru_core_bench;

    logic        clk;
    logic        rst_n;
    logic        exec_i;
    logic [12:0] instr_i;
    logic [17:0] ac_i;
    logic [17:0] io_i;
    logic [17:0] ac_o;
    logic [17:0] io_o;
    logic        done_o;

    int checks;
    int errors;

    sru_core u_sru_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .exec_i  (exec_i),
        .instr_i (instr_i),
        .ac_i    (ac_i),
        .io_i    (io_i),
        .ac_o    (ac_o),
        .io_o    (io_o),
        .done_o  (done_o)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // One step at a time, written from the requirement text.
    function automatic logic [17:0] step18(logic [17:0] w, logic right, logic arith);
        if (!arith) return right ? {w[0], w[17:1]} : {w[16:0], w[17]};
        return right ? {w[17], w[17], w[16:1]} : {w[17], w[15:0], w[17]};
    endfunction

    function automatic logic [35:0] step36(logic [35:0] w, logic right, logic arith);
        if (!arith) return right ? {w[0], w[35:1]} : {w[34:0], w[35]};
        return right ? {w[35], w[35], w[34:1]} : {w[35], w[33:0], w[35]};
    endfunction

    function automatic logic [35:0] model(logic [12:0] ins, logic [17:0] a, logic [17:0] b);
        logic [35:0] p;
        int n;
        n = 0;
        for (int k = 0; k < 9; k++) n += int'(ins[k]);
        p = {a, b};
        for (int s = 0; s < n; s++) begin
            case (ins[10:9])
                2'b01:   a = step18(a, ins[12], ins[11]);
                2'b10:   b = step18(b, ins[12], ins[11]);
                2'b11:   p = step36(p, ins[12], ins[11]);
                default: ;
            endcase
        end
        return (ins[10:9] == 2'b11) ? p : {a, b};
    endfunction

    function automatic string tag_of(logic [12:0] ins);
        if (ins[8:0] == 9'd0)    return "R8";
        if (ins[10:9] == 2'b00)  return "R7";
        if (!ins[11])            return "R3";
        if (ins[10:9] == 2'b11)  return "R6";
        if (ins[12])             return "R4";
        return "R5";
    endfunction

    task automatic check(string tag, logic [35:0] got, logic [35:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %o expected %o", tag, got, exp);
        end
    endtask

    // Drive one operation at a falling edge, sample at the next.
    task automatic run_op(logic [12:0] ins, logic [17:0] a, logic [17:0] b);
        @(negedge clk);
        exec_i  = 1'b1;
        instr_i = ins;
        ac_i    = a;
        io_i    = b;
        @(negedge clk);
        exec_i  = 1'b0;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [17:0] pat_a [4];
        logic [17:0] pat_b [4];
        checks  = 0;
        errors  = 0;
        rst_n   = 1'b0;
        exec_i  = 1'b0;
        instr_i = '0;
        ac_i    = '0;
        io_i    = '0;
        pat_a[0] = 18'o123456; pat_b[0] = 18'o654321;
        pat_a[1] = 18'o400001; pat_b[1] = 18'o377776;
        pat_a[2] = 18'o777777; pat_b[2] = 18'o000000;
        pat_a[3] = 18'o525252; pat_b[3] = 18'o252525;

        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", {ac_o, io_o}, 36'd0);
        check("R10", {35'd0, done_o}, 36'd0);
        rst_n = 1'b1;

        // R1: rotate AC right nine places (field all ones)
        run_op(13'b1_0_01_111111111, 18'o123456, 18'o111111);
        check("R1", {ac_o, io_o}, {18'o456123, 18'o111111});
        // R9: done pulses in the cycle after the strobe
        check("R9", {35'd0, done_o}, 36'd1);
        // R1: rotate AC right one place
        run_op(13'b1_0_01_000000001, 18'o000001, 18'o0);
        check("R1", {ac_o, io_o}, {18'o400000, 18'o0});
        // R5: AC arithmetic left, positive and negative
        run_op(13'b0_1_01_000000001, 18'o000003, 18'o0);
        check("R5", {ac_o, io_o}, {18'o000006, 18'o0});
        run_op(13'b0_1_01_000000001, 18'o777776, 18'o0);
        check("R5", {ac_o, io_o}, {18'o777775, 18'o0});
        // R4: arithmetic right of maximum-magnitude negative word
        run_op(13'b1_1_01_000000001, 18'o400000, 18'o0);
        check("R4", {ac_o, io_o}, {18'o600000, 18'o0});
        // R6: joined right shift crosses from AC bit 0 into IO bit 17
        run_op(13'b1_1_11_000000001, 18'o000001, 18'o000000);
        check("R6", {ac_o, io_o}, {18'o000000, 18'o400000});
        // R3: joined right rotate carries IO bit 0 to AC bit 17
        run_op(13'b1_0_11_000000001, 18'o000000, 18'o000001);
        check("R3", {ac_o, io_o}, {18'o400000, 18'o000000});

        // R2: each single field bit gives exactly one step
        for (int k = 0; k < 9; k++) begin
            run_op(13'b1_0_01_000000000 | (13'd1 << k), 18'o000001, 18'o0);
            check("R2", {ac_o, io_o}, {18'o400000, 18'o0});
        end

        // R10: idle cycle holds outputs, done low
        @(negedge clk);
        ac_i    = 18'o707070;
        io_i    = 18'o070707;
        instr_i = 13'b0_0_11_111111111;
        @(negedge clk);
        check("R10", {ac_o, io_o}, {18'o400000, 18'o0});
        check("R9", {35'd0, done_o}, 36'd0);

        // Sweep of all modes and step fields over the data patterns
        for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < 16; m++) begin
                for (int f = 0; f < 512; f++) begin
                    logic [12:0] ins;
                    ins = {m[3:0], f[8:0]};
                    run_op(ins, pat_a[p], pat_b[p]);
                    check(tag_of(ins), {ac_o, io_o}, model(ins, pat_a[p], pat_b[p]));
                end
            end
            check("R9", {35'd0, done_o}, 36'd1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule